// File: doc/BRIEF.md
# Lane FIFO Pair with Sticky Error Flags

This block is the data buffering for one state-machine lane. A transmit FIFO carries words from the system to the lane, and a receive FIFO carries words from the lane back to the system. Each FIFO is 32 bits wide and 4 entries deep. Both FIFOs are show-ahead: the word at the head is always present on the read data output, and a pop or pull advances past it at the next clock edge.

Neither side is made to wait. An access that cannot complete is dropped: a system push into a full transmit FIFO, a system pop from an empty receive FIFO, a lane pull from an empty transmit FIFO, or a lane push into a full receive FIFO. A dropped access leaves the FIFO pointers, count and contents exactly as they were. Each kind of drop raises its own sticky flag. Software clears a flag by writing a 1 to its bit.

A single clear command empties both FIFOs at once. It does not touch the error flags. The lane's shift registers and execution logic sit outside the block.

Top module: `lane_fifo_pair`

## Requirements
- R1: After reset both FIFOs are empty and not full, and all four error flags read 0.
- R2: Each FIFO returns words in the order they were accepted and holds up to 4 words. It reports full after 4 accepted pushes with no pops in between.
- R3: A system push while the transmit FIFO is full is dropped. The head word, the stored order and the full status are unchanged. This holds even when a lane pull happens in the same cycle: the pull is accepted and the push is still dropped.
- R4: A system push while the transmit FIFO is full sets error flag bit 0 (transmit overflow) in the next cycle.
- R5: A system pop while the receive FIFO is empty leaves it empty. Words pushed by the lane afterwards come out intact and in order. The read data during such a pop is undefined and is not checked.
- R6: A system pop while the receive FIFO is empty sets error flag bit 1 (receive underflow) in the next cycle.
- R7: A lane pull from an empty transmit FIFO is dropped and sets flag bit 2. A lane push into a full receive FIFO is dropped and sets flag bit 3. The stored words are unchanged in both cases.
- R8: A set flag stays at 1 until a cycle in which sys_err_clr has a 1 in that bit position; it then reads 0 in the next cycle. A 0 in sys_err_clr leaves the flag unchanged. A new error in the same cycle as a clear leaves the flag set.
- R9: sys_clear empties both FIFOs by the next cycle, and any push or pop in that cycle has no effect on contents. The error flags are unchanged by sys_clear, though an error detected in that cycle is still recorded.
- R10: Full and empty status change in the cycle after the push or pop that causes them. A push and a pop in the same cycle at an occupancy of 1 to 3 keep the occupancy unchanged and keep the word order.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sys_tx_push | input | 1 | System writes sys_tx_data into the transmit FIFO |
| sys_tx_data | input | 32 | System write data |
| sys_rx_pop | input | 1 | System removes the receive head word |
| sys_rx_data | output | 32 | Receive head word (show-ahead) |
| sys_clear | input | 1 | Empty both FIFOs |
| sys_err_clr | input | 4 | Write-1-to-clear mask for the error flags |
| err_flags | output | 4 | Sticky flags: bit0 tx overflow, bit1 rx underflow, bit2 tx pull-empty, bit3 rx push-full |
| lane_tx_pull | input | 1 | Lane removes the transmit head word |
| lane_tx_data | output | 32 | Transmit head word (show-ahead) |
| lane_rx_push | input | 1 | Lane writes lane_rx_data into the receive FIFO |
| lane_rx_data | input | 32 | Lane write data |
| tx_full | output | 1 | Transmit FIFO holds 4 words |
| tx_empty | output | 1 | Transmit FIFO holds no words |
| rx_full | output | 1 | Receive FIFO holds 4 words |
| rx_empty | output | 1 | Receive FIFO holds no words |

## Verification
The bench drives directed sequences on both FIFOs:
- Plain fill-and-drain runs confirm ordering and the status timing.
- Pushes into a full FIFO and pops from an empty one separate a correctly dropped access from one that overwrites a word or moves a pointer. A later drain exposes either fault through wrong data or wrong status.
- Simultaneous push and pop, both at middle occupancy and at the full boundary, separate a count that nets to zero from one that drifts.
- Flag clear-and-set collisions and a clear that coincides with a push each test one priority rule on its own.

A final stretch of random traffic on all inputs mixes these cases against a queue model of both FIFOs.

// File: rtl/lfp_pkg.sv
package lfp_pkg;
  localparam int NUM_FLAGS = 4;

  typedef enum int unsigned {
    FLG_TX_OVF   = 0,
    FLG_RX_UNF   = 1,
    FLG_TX_STARV = 2,
    FLG_RX_DROP  = 3
  } flag_idx_e;
endpackage

// File: rtl/lfp_fifo.sv
module lfp_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         full,
  output logic         empty,
  output logic         push_drop,
  output logic         pop_drop
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  function automatic logic [AW-1:0] ptr_adv(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [CW-1:0] cnt_next(input logic [CW-1:0] c,
                                             input logic inc,
                                             input logic dec);
    return c + CW'(inc) - CW'(dec);
  endfunction

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rptr, wptr;
  logic [CW-1:0] count;
  logic          push_ok, pop_ok;

  assign full      = (count == CW'(DEPTH));
  assign empty     = (count == '0);
  assign push_ok   = push & ~full;
  assign pop_ok    = pop & ~empty;
  assign push_drop = push & full;
  assign pop_drop  = pop & empty;
  assign rdata     = mem[rptr];

  always_ff @(posedge clk) begin
    if (push_ok && !clear) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr  <= '0;
      wptr  <= '0;
      count <= '0;
    end else if (clear) begin
      rptr  <= '0;
      wptr  <= '0;
      count <= '0;
    end else begin
      if (push_ok) wptr <= ptr_adv(wptr);
      if (pop_ok)  rptr <= ptr_adv(rptr);
      count <= cnt_next(count, push_ok, pop_ok);
    end
  end
endmodule

// File: rtl/lfp_sticky.sv
module lfp_sticky #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_evt,
  input  logic [N-1:0] clr_req,
  output logic [N-1:0] flags
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flags[i] <= 1'b0;
      else if (set_evt[i]) flags[i] <= 1'b1;
      else if (clr_req[i]) flags[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/lane_fifo_pair.sv
module lane_fifo_pair #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        sys_tx_push,
  input  logic [DATA_W-1:0]           sys_tx_data,
  input  logic                        sys_rx_pop,
  output logic [DATA_W-1:0]           sys_rx_data,
  input  logic                        sys_clear,
  input  logic [lfp_pkg::NUM_FLAGS-1:0] sys_err_clr,
  output logic [lfp_pkg::NUM_FLAGS-1:0] err_flags,
  input  logic                        lane_tx_pull,
  output logic [DATA_W-1:0]           lane_tx_data,
  input  logic                        lane_rx_push,
  input  logic [DATA_W-1:0]           lane_rx_data,
  output logic                        tx_full,
  output logic                        tx_empty,
  output logic                        rx_full,
  output logic                        rx_empty
);
  import lfp_pkg::*;

  logic tx_push_drop, tx_pull_drop, rx_push_drop, rx_pop_drop;
  logic [NUM_FLAGS-1:0] err_evt;

  lfp_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_tx (
    .clk(clk), .rst_n(rst_n), .clear(sys_clear),
    .push(sys_tx_push), .wdata(sys_tx_data),
    .pop(lane_tx_pull), .rdata(lane_tx_data),
    .full(tx_full), .empty(tx_empty),
    .push_drop(tx_push_drop), .pop_drop(tx_pull_drop)
  );

  lfp_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_rx (
    .clk(clk), .rst_n(rst_n), .clear(sys_clear),
    .push(lane_rx_push), .wdata(lane_rx_data),
    .pop(sys_rx_pop), .rdata(sys_rx_data),
    .full(rx_full), .empty(rx_empty),
    .push_drop(rx_push_drop), .pop_drop(rx_pop_drop)
  );

  always_comb begin
    err_evt               = '0;
    err_evt[FLG_TX_OVF]   = tx_push_drop;
    err_evt[FLG_RX_UNF]   = rx_pop_drop;
    err_evt[FLG_TX_STARV] = tx_pull_drop;
    err_evt[FLG_RX_DROP]  = rx_push_drop;
  end

  lfp_sticky #(.N(NUM_FLAGS)) u_flags (
    .clk(clk), .rst_n(rst_n),
    .set_evt(err_evt), .clr_req(sys_err_clr),
    .flags(err_flags)
  );
endmodule

// File: rtl/lfp_checker.sv
module lfp_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sys_tx_push,
  input logic              sys_rx_pop,
  input logic              sys_clear,
  input logic [3:0]        sys_err_clr,
  input logic [3:0]        err_flags,
  input logic              lane_tx_pull,
  input logic              lane_rx_push,
  input logic [DATA_W-1:0] lane_tx_data,
  input logic              tx_full,
  input logic              tx_empty,
  input logic              rx_full,
  input logic              rx_empty,
  input logic [3:0]        err_evt
);
  AST_TX_FULL_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_full && sys_tx_push && !lane_tx_pull && !sys_clear) |=> (tx_full && $stable(lane_tx_data))); // R3
  AST_TX_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_full && sys_tx_push) |=> err_flags[0]); // R4
  AST_RX_UNDER_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_empty && sys_rx_pop && !lane_rx_push) |=> rx_empty); // R5
  AST_RX_UNF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_empty && sys_rx_pop) |=> err_flags[1]); // R6
  AST_LANE_ERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ((tx_empty && lane_tx_pull) || (rx_full && lane_rx_push)) |=> (err_flags[2] || err_flags[3])); // R7
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flags[0] && !sys_err_clr[0]) |=> err_flags[0]); // R8
  AST_FLAG_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_err_clr[1] && !err_evt[1]) |=> !err_flags[1]); // R8
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    sys_clear |=> (tx_empty && rx_empty)); // R9
  AST_MID_BALANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_empty && !tx_full && sys_tx_push && lane_tx_pull && !sys_clear) |=> (!tx_empty && !tx_full)); // R10
  AST_STATUS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_full && tx_empty) && !(rx_full && rx_empty)); // R2
endmodule

bind lane_fifo_pair lfp_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sys_tx_push(sys_tx_push), .sys_rx_pop(sys_rx_pop),
  .sys_clear(sys_clear), .sys_err_clr(sys_err_clr), .err_flags(err_flags),
  .lane_tx_pull(lane_tx_pull), .lane_rx_push(lane_rx_push), .lane_tx_data(lane_tx_data),
  .tx_full(tx_full), .tx_empty(tx_empty), .rx_full(rx_full), .rx_empty(rx_empty),
  .err_evt(err_evt)
);

// File: tb/tb_lane_fifo_pair.sv
module tb_lane_fifo_pair;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sys_tx_push = 1'b0, sys_rx_pop = 1'b0, sys_clear = 1'b0;
  logic        lane_tx_pull = 1'b0, lane_rx_push = 1'b0;
  logic [31:0] sys_tx_data = '0, lane_rx_data = '0;
  logic [3:0]  sys_err_clr = '0;
  logic [31:0] sys_rx_data, lane_tx_data;
  logic [3:0]  err_flags;
  logic        tx_full, tx_empty, rx_full, rx_empty;

  int n_tests = 0;
  int n_fail  = 0;
  logic [31:0] txq[$];
  logic [31:0] rxq[$];
  logic [3:0]  mflags = '0;
  string       cur_tag = "R1";

  always #5 clk = ~clk;

  lane_fifo_pair dut (
    .clk(clk), .rst_n(rst_n),
    .sys_tx_push(sys_tx_push), .sys_tx_data(sys_tx_data),
    .sys_rx_pop(sys_rx_pop), .sys_rx_data(sys_rx_data),
    .sys_clear(sys_clear), .sys_err_clr(sys_err_clr), .err_flags(err_flags),
    .lane_tx_pull(lane_tx_pull), .lane_tx_data(lane_tx_data),
    .lane_rx_push(lane_rx_push), .lane_rx_data(lane_rx_data),
    .tx_full(tx_full), .tx_empty(tx_empty), .rx_full(rx_full), .rx_empty(rx_empty)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Monitor: compares head words against the scoreboard before each edge
  always begin
    @(negedge clk);
    #2;
    if (rst_n && lane_tx_pull && txq.size() > 0)
      chk(cur_tag, "lane_tx_data", lane_tx_data, txq[0]);
    if (rst_n && sys_rx_pop && rxq.size() > 0)
      chk(cur_tag, "sys_rx_data", sys_rx_data, rxq[0]);
  end

  // Driver: one cycle of stimulus, scoreboard update, then status checks
  task automatic cyc(input string tag, input logic tp, input logic [31:0] td,
                     input logic lp, input logic rp, input logic [31:0] rd,
                     input logic sp, input logic cl, input logic [3:0] ec);
    int tn, rn;
    logic [3:0] ev;
    cur_tag = tag;
    sys_tx_push = tp; sys_tx_data = td; lane_tx_pull = lp;
    lane_rx_push = rp; lane_rx_data = rd; sys_rx_pop = sp;
    sys_clear = cl; sys_err_clr = ec;
    @(posedge clk);
    tn = txq.size(); rn = rxq.size();
    ev = {rp && rn == 4, lp && tn == 0, sp && rn == 0, tp && tn == 4};
    if (cl) begin
      txq.delete(); rxq.delete();
    end else begin
      if (lp && tn > 0) void'(txq.pop_front());
      if (tp && tn < 4) txq.push_back(td);
      if (sp && rn > 0) void'(rxq.pop_front());
      if (rp && rn < 4) rxq.push_back(rd);
    end
    mflags = (mflags & ~ec) | ev;
    @(negedge clk);
    chk(tag, "tx_full",   32'(tx_full),   32'(txq.size() == 4));
    chk(tag, "tx_empty",  32'(tx_empty),  32'(txq.size() == 0));
    chk(tag, "rx_full",   32'(rx_full),   32'(rxq.size() == 4));
    chk(tag, "rx_empty",  32'(rx_empty),  32'(rxq.size() == 0));
    chk(tag, "err_flags", 32'(err_flags), 32'(mflags));
    if (txq.size() > 0) chk(tag, "tx head", lane_tx_data, txq[0]);
    if (rxq.size() > 0) chk(tag, "rx head", sys_rx_data, rxq[0]);
  endtask

  task automatic idle(input string tag);
    cyc(tag, 0, 0, 0, 0, 0, 0, 0, 4'h0);
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "tx_empty", 32'(tx_empty), 1);
    chk("R1", "tx_full",  32'(tx_full),  0);
    chk("R1", "rx_empty", 32'(rx_empty), 1);
    chk("R1", "rx_full",  32'(rx_full),  0);
    chk("R1", "err_flags", 32'(err_flags), 0);

    // R2 fill and drain in order; R10 status timing checked each cycle
    for (int i = 0; i < 4; i++) cyc("R2", 1, 32'hA000_0000 + i, 0, 0, 0, 0, 0, 4'h0);
    for (int i = 0; i < 4; i++) cyc("R2", 0, 0, 1, 0, 0, 0, 0, 4'h0);
    for (int i = 0; i < 4; i++) cyc("R2", 0, 0, 0, 1, 32'hB000_0000 + i, 0, 0, 4'h0);
    for (int i = 0; i < 4; i++) cyc("R2", 0, 0, 0, 0, 0, 1, 0, 4'h0);

    // R3 / R4 push to full TX is dropped and flagged
    for (int i = 0; i < 4; i++) cyc("R3", 1, 32'h1111_0000 + i, 0, 0, 0, 0, 0, 4'h0);
    cyc("R4", 1, 32'hDEAD_BEEF, 0, 0, 0, 0, 0, 4'h0);
    cyc("R3", 1, 32'hDEAD_0001, 1, 0, 0, 0, 0, 4'h0);
    for (int i = 0; i < 3; i++) cyc("R3", 0, 0, 1, 0, 0, 0, 0, 4'h0);

    // R8 sticky behaviour
    cyc("R8", 0, 0, 0, 0, 0, 0, 0, 4'h0);
    cyc("R8", 0, 0, 0, 0, 0, 0, 0, 4'hE);
    cyc("R8", 0, 0, 0, 0, 0, 0, 0, 4'h1);

    // R5 / R6 pop from empty RX
    cyc("R6", 0, 0, 0, 0, 0, 1, 0, 4'h0);
    cyc("R5", 0, 0, 0, 0, 0, 1, 0, 4'h0);
    for (int i = 0; i < 3; i++) cyc("R5", 0, 0, 0, 1, 32'hC0DE_0000 + i, 0, 0, 4'h0);
    for (int i = 0; i < 3; i++) cyc("R5", 0, 0, 0, 0, 0, 1, 0, 4'h0);

    // R8 set wins over clear in same cycle
    cyc("R8", 0, 0, 0, 0, 0, 1, 0, 4'h2);
    cyc("R8", 0, 0, 0, 0, 0, 0, 0, 4'h2);

    // R7 lane-side drops
    cyc("R7", 0, 0, 1, 0, 0, 0, 0, 4'h0);
    for (int i = 0; i < 4; i++) cyc("R7", 0, 0, 0, 1, 32'h7700_0000 + i, 0, 0, 4'h0);
    cyc("R7", 0, 0, 0, 1, 32'hBAD0_BAD0, 0, 0, 4'h0);
    for (int i = 0; i < 4; i++) cyc("R7", 0, 0, 0, 0, 0, 1, 0, 4'h0);

    // R10 simultaneous push and pull at middle occupancy
    cyc("R10", 1, 32'h5500_0000, 0, 0, 0, 0, 0, 4'h0);
    cyc("R10", 1, 32'h5500_0001, 0, 0, 0, 0, 0, 4'h0);
    for (int i = 2; i < 10; i++) cyc("R10", 1, 32'h5500_0000 + i, 1, 1, 32'h6600_0000 + i, 1, 0, 4'h0);

    // R9 clear with simultaneous push; flags untouched
    for (int i = 0; i < 3; i++) cyc("R9", 0, 0, 0, 1, 32'h9900_0000 + i, 0, 0, 4'h0);
    cyc("R9", 1, 32'hFFFF_0000, 0, 1, 32'hFFFF_0001, 0, 1, 4'h0);
    idle("R9");
    cyc("R9", 1, 32'h9A00_0000, 0, 1, 32'h9B00_0000, 0, 0, 4'h0);
    cyc("R9", 0, 0, 1, 0, 0, 1, 0, 4'hF);

    // Random mix against the scoreboard
    for (int i = 0; i < 600; i++) begin
      logic [31:0] r;
      r = $urandom;
      cyc("R2", r[0], $urandom, r[1], r[2], $urandom, r[3],
          (r[11:4] == 8'h00), (r[15:12] == 4'h0) ? r[19:16] : 4'h0);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule